// File: doc/BRIEF.md
# Round-Robin Measurement Sequencer with Sample Averaging

This block keeps a shared analog-to-digital converter busy without pause. It visits a fixed list of measurement channels in turn and, for each visit, asks the converter for one conversion with a start pulse. It then waits for the converter's done strobe, which comes with a 10-bit result. The final value for each channel goes into that channel's own value register. When averaging is selected, each visit takes sixteen conversions, and the register receives their sum divided by sixteen, rounded down.

Two configuration inputs change the channel list. The first chooses whether the shared analog pin pair serves as a remote temperature diode or as two single-ended inputs. The second marks the third single-ended input as unavailable because its pin serves another function. A third input selects averaging. The block reads all three at the start of a pass, so a pass always runs with the settings it started with. Once the last channel of a pass is stored, a one-clock pass-complete pulse marks the boundary, and the next pass starts again with the supply channel.

Top module: `rrm_seq`

## Requirements
- R1: Channel codes on `conv_chan` are 0 supply, 1 on-die temperature, 2 remote diode temperature, 3 input 1, 4 input 2, 5 input 3, 6 input 4. With `cfg_diode`=0 and `cfg_in3_off`=0, a pass visits 0,1,3,4,5,6 in that order.
- R2: With `cfg_diode`=1, the single code 2 takes the place of codes 3 and 4, and the pass visits 0,1,2,5,6.
- R3: With `cfg_in3_off`=1, code 5 is left out of the pass in either pin-pair mode.
- R4: With averaging off, each visit makes one conversion, and the channel's register takes that conversion's 10-bit result.
- R5: With averaging on, each visit makes 16 conversions. The register takes floor(sum/16) of the 16 results, and the sum is kept at 14 bits, so sixteen results of 1023 store 1023.
- R6: A value register changes only in the cycle after the done strobe that completes its channel's visit. All other registers, and that register during earlier samples, hold their value.
- R7: `cycle_done` is high for exactly one clock, in the same cycle in which the pass's last register shows its new value. In that cycle `conv_start` is high with `conv_chan`=0.
- R8: A change of any configuration input during a pass does not alter that pass's channel list or sample count. It takes effect from the next pass.
- R9: `conv_start` is a one-cycle pulse. After a pulse, no new pulse comes until the done strobe for that conversion has been accepted.
- R10: After reset, all value registers read 0, `cycle_done` is 0, and the first conversion requested is for channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_diode | input | 1 | 1: pin pair is a remote diode; 0: two single-ended inputs |
| cfg_in3_off | input | 1 | 1: input 3 is not measured |
| cfg_avg | input | 1 | 1: average 16 conversions per channel |
| conv_start | output | 1 | One-cycle request for a conversion |
| conv_chan | output | 3 | Channel code of the requested conversion |
| conv_done | input | 1 | Conversion result valid strobe |
| conv_data | input | 10 | Conversion result |
| val_flat | output | 70 | Value registers, channel k at bits [10k+9:10k] |
| cycle_done | output | 1 | One-cycle pulse after the last channel of a pass is stored |

## Verification
Three things happen in one clock. The last channel's register is written, the pass-complete pulse rises, and the first start pulse of the next pass goes out, using configuration just read from the inputs. To provoke this, the bench sweeps every combination of pin-pair mode, input-3 availability and averaging. In each pass it changes the inputs partway through, so every boundary latches a new setting. At the negedge after each completing done strobe, the bench compares all seven registers with values it has computed from the sampled results. In that same cycle it checks the pulse, and it checks that the start request is for channel 0. It checks each pass's order against a list built from the inputs seen at the pass's first request.

// File: rtl/rrm_pkg.sv
// Shared types for the round-robin measurement sequencer.
// Assumes a fixed set of seven channel codes; the codes are decoded by the converter.
package rrm_pkg;
    localparam int CHAN_W = 3;
    localparam int NUM_CH = 7;

    typedef enum logic [CHAN_W-1:0] {
        CH_SUPPLY = 3'd0,
        CH_TINT   = 3'd1,
        CH_TEXT   = 3'd2,
        CH_IN1    = 3'd3,
        CH_IN2    = 3'd4,
        CH_IN3    = 3'd5,
        CH_IN4    = 3'd6
    } chan_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KICK = 2'd1,
        ST_WAIT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/rrm_order.sv
// Next-channel decoder. Given the current channel and the configuration
// latched for the pass, it gives the channel that follows and flags the last slot.
// Assumes the supply channel always opens a pass and input 4 always closes it.
module rrm_order
    import rrm_pkg::*;
(
    input  chan_e cur,
    input  logic  diode,
    input  logic  in3_off,
    output chan_e nxt,
    output logic  is_last
);
    // Purpose: fixed order with the pin-pair and input-3 variants.
    always_comb begin
        unique case (cur)
            CH_SUPPLY: nxt = CH_TINT;
            CH_TINT:   nxt = diode ? CH_TEXT : CH_IN1;
            CH_TEXT:   nxt = in3_off ? CH_IN4 : CH_IN3;
            CH_IN1:    nxt = CH_IN2;
            CH_IN2:    nxt = in3_off ? CH_IN4 : CH_IN3;
            CH_IN3:    nxt = CH_IN4;
            default:   nxt = CH_SUPPLY;
        endcase
    end

    assign is_last = (cur == CH_IN4);
endmodule

// File: rtl/rrm_accum.sv
// Sample accumulator. Counts the conversions of one channel visit, sums them,
// and presents the final value together with a flag that marks the last sample.
// Assumes take is high for exactly one cycle per accepted conversion.
module rrm_accum #(
    parameter int DATA_W   = 10,
    parameter int AVG_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              avg_on,
    input  logic [DATA_W-1:0] din,
    output logic              fin_last,
    output logic [DATA_W-1:0] fin_val
);
    localparam int SUM_W = DATA_W + AVG_LOG2;

    logic [AVG_LOG2-1:0] cnt;
    logic [SUM_W-1:0]    sum;
    logic [SUM_W-1:0]    sum_nx;

    // Purpose: running sum including the sample now offered.
    always_comb begin
        sum_nx   = sum + SUM_W'(din);
        fin_last = !avg_on || (cnt == {AVG_LOG2{1'b1}});
        fin_val  = avg_on ? sum_nx[SUM_W-1:AVG_LOG2] : din;
    end

    // Purpose: advance or clear the sample count and sum on each accepted conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sum <= '0;
        end else if (take) begin
            if (fin_last) begin
                cnt <= '0;
                sum <= '0;
            end else begin
                cnt <= cnt + 1'b1;
                sum <= sum_nx;
            end
        end
    end
endmodule

// File: rtl/rrm_bank.sv
// Per-channel value registers. One register per channel code, written
// when wr is high and sel matches its code.
// Assumes at most one write per cycle.
module rrm_bank #(
    parameter int DATA_W = 10,
    parameter int NCH    = 7,
    parameter int SEL_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [SEL_W-1:0]      sel,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NCH*DATA_W-1:0] flat
);
    for (genvar k = 0; k < NCH; k++) begin : g_reg
        logic [DATA_W-1:0] val;

        // Purpose: hold the last stored result for channel k.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val <= '0;
            else if (wr && (sel == SEL_W'(k)))
                val <= wdata;
        end

        assign flat[k*DATA_W +: DATA_W] = val;
    end
endmodule

// File: rtl/rrm_seq.sv
// Round-robin measurement sequencer (top). Requests conversions one at a time,
// averages per channel when enabled, stores results and pulses at each pass end.
// Assumes the converter answers each start pulse with exactly one done strobe.
// Configuration inputs are sampled once, on the first request of each pass.
module rrm_seq
    import rrm_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int AVG_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_diode,
    input  logic                     cfg_in3_off,
    input  logic                     cfg_avg,
    output logic                     conv_start,
    output logic [CHAN_W-1:0]        conv_chan,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    output logic [NUM_CH*DATA_W-1:0] val_flat,
    output logic                     cycle_done
);
    seq_st_e           st;
    chan_e             chan;
    chan_e             chan_nx;
    logic              chan_last;
    logic              pass_new;
    logic              lat_diode;
    logic              lat_in3_off;
    logic              lat_avg;
    logic              accept;
    logic              fin_last;
    logic [DATA_W-1:0] fin_val;

    assign accept     = (st == ST_WAIT) && conv_done;
    assign conv_start = (st == ST_KICK);
    assign conv_chan  = chan;

    rrm_order u_order (
        .cur     (chan),
        .diode   (lat_diode),
        .in3_off (lat_in3_off),
        .nxt     (chan_nx),
        .is_last (chan_last)
    );

    rrm_accum #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (accept),
        .avg_on   (lat_avg),
        .din      (conv_data),
        .fin_last (fin_last),
        .fin_val  (fin_val)
    );

    rrm_bank #(.DATA_W(DATA_W), .NCH(NUM_CH), .SEL_W(CHAN_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (accept && fin_last),
        .sel   (chan),
        .wdata (fin_val),
        .flat  (val_flat)
    );

    // Purpose: request/wait sequencing, channel stepping, pass latch and pass-end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            chan        <= CH_SUPPLY;
            pass_new    <= 1'b1;
            lat_diode   <= 1'b0;
            lat_in3_off <= 1'b0;
            lat_avg     <= 1'b0;
            cycle_done  <= 1'b0;
        end else begin
            cycle_done <= 1'b0;
            unique case (st)
                ST_IDLE: st <= ST_KICK;
                ST_KICK: begin
                    if (pass_new) begin
                        lat_diode   <= cfg_diode;
                        lat_in3_off <= cfg_in3_off;
                        lat_avg     <= cfg_avg;
                        pass_new    <= 1'b0;
                    end
                    st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (accept) begin
                        st <= ST_KICK;
                        if (fin_last) begin
                            if (chan_last) begin
                                chan       <= CH_SUPPLY;
                                pass_new   <= 1'b1;
                                cycle_done <= 1'b1;
                            end else begin
                                chan <= chan_nx;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rrm_seq_chk.sv
// Property checker for rrm_seq, attached by bind. Watches ports only.
module rrm_seq_chk #(
    parameter int DATA_W = 10,
    parameter int NCH    = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  conv_start,
    input logic [2:0]            conv_chan,
    input logic                  conv_done,
    input logic [NCH*DATA_W-1:0] val_flat,
    input logic                  cycle_done
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R9
    AST_PASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done); // R7
    AST_PASS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (conv_start && conv_chan == 3'd0)); // R7
    AST_VALUES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(val_flat)); // R6
    AST_CHAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != 3'd7)); // R1
endmodule

bind rrm_seq rrm_seq_chk #(.DATA_W(DATA_W), .NCH(rrm_pkg::NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .val_flat   (val_flat),
    .cycle_done (cycle_done)
);

// File: tb/rrm_seq_test.sv
module rrm_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_diode = 1'b0;
    logic       cfg_in3_off = 1'b0;
    logic       cfg_avg = 1'b0;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic [69:0] val_flat;
    logic       cycle_done;

    int checks = 0;
    int errors = 0;
    int passes = 0;
    int seqn = 0;
    bit pat = 1'b0;
    bit mid = 1'b0;
    bit finished = 1'b0;

    int list [7];
    int nslots = 0;
    int slot = 0;
    bit pass_avg = 1'b0;
    bit pass_diode = 1'b0;
    bit pass_in3 = 1'b0;
    int bsum [7];
    int bcnt [7];
    int exp_v [7];

    always #5 clk = ~clk;

    rrm_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_diode(cfg_diode), .cfg_in3_off(cfg_in3_off),
        .cfg_avg(cfg_avg), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .val_flat(val_flat),
        .cycle_done(cycle_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic build_list();
        nslots = 0;
        list[nslots++] = 0;
        list[nslots++] = 1;
        if (pass_diode) list[nslots++] = 2;
        else begin list[nslots++] = 3; list[nslots++] = 4; end
        if (!pass_in3) list[nslots++] = 5;
        list[nslots++] = 6;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Converter model and result checker, all activity at negedges.
    initial begin
        for (int k = 0; k < 7; k++) begin bsum[k] = 0; bcnt[k] = 0; exp_v[k] = 0; end
        wait (rst_n);
        forever begin
            int ch, d, n;
            bit ch_done, last_pass;
            string otag, vtag;
            while (!conv_start) @(negedge clk);
            ch = int'(conv_chan);
            if (slot == 0 && bcnt[0] == 0) begin
                pass_diode = cfg_diode;
                pass_in3   = cfg_in3_off;
                pass_avg   = cfg_avg;
                mid = 1'b0;
                build_list();
            end
            otag = mid ? "R8" : (pass_in3 ? "R3" : (pass_diode ? "R2" : "R1"));
            chk(ch == list[slot], otag, ch, list[slot]);
            if (slot == 0 && passes == 0) chk(ch == 0, "R10", ch, 0);
            @(negedge clk);
            chk(conv_start == 1'b0, "R9", int'(conv_start), 0);
            @(negedge clk);
            chk(conv_start == 1'b0, "R9", int'(conv_start), 0);
            if (pat) d = 1023 - ((bcnt[ch] * 5 + ch) % 8);
            else     d = (ch * 97 + seqn * 13) % 1024;
            seqn++;
            conv_done = 1'b1;
            conv_data = 10'(d);
            @(negedge clk);
            conv_done = 1'b0;
            conv_data = '0;
            bsum[ch] += d;
            bcnt[ch]++;
            n = pass_avg ? 16 : 1;
            ch_done = (bcnt[ch] == n);
            if (ch_done) begin
                exp_v[ch] = bsum[ch] / n;
                bsum[ch] = 0;
                bcnt[ch] = 0;
            end
            vtag = ch_done ? (pass_avg ? "R5" : "R4") : "R6";
            for (int k = 0; k < 7; k++)
                chk(int'(val_flat[k*10 +: 10]) == exp_v[k], vtag,
                    int'(val_flat[k*10 +: 10]), exp_v[k]);
            last_pass = ch_done && (slot == nslots - 1);
            chk(cycle_done == last_pass, "R7", int'(cycle_done), int'(last_pass));
            if (last_pass) begin
                chk(conv_start && conv_chan == 3'd0, "R7", int'(conv_chan), 0);
                slot = 0;
                passes++;
            end else if (ch_done) begin
                slot++;
            end
        end
    end

    // Stimulus: reset check, then one mid-pass configuration change per pass.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(val_flat == '0, "R10", int'(val_flat[9:0]), 0);
        chk(cycle_done == 1'b0, "R10", int'(cycle_done), 0);
        chk(conv_start == 1'b0, "R10", int'(conv_start), 0);
        for (int c = 1; c <= 16; c++) begin
            repeat (9) @(posedge clk);
            #2;
            cfg_diode   = c[0];
            cfg_in3_off = c[1];
            cfg_avg     = c[2];
            pat         = c[3];
            mid         = 1'b1;
            while (passes < c) @(posedge clk);
        end
        repeat (4) @(posedge clk);
        finish_run();
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d passes", passes, 16);
        finish_run();
    end
endmodule